// File: doc/BRIEF.md
# Two-Core Stereo Sound Mix Router

The block is the mixing stage of a sample-rate audio engine built from two identical cores. Each core takes 24 stereo voice outputs, a streamed PCM data input and an external input. It sums them onto four buses: dry left, dry right, wet left and wet right. Routing works at two levels. Four 24-bit masks decide, voice by voice, which buses a voice reaches. A 12-bit mixer-enable word then gates each source group onto each bus. The data input and the external input are each scaled by their own signed stereo volume before routing.

The wet buses go out as the send to an external effect unit. The dry buses are added to the returned effect signal, which is scaled by an effect-return volume. That sum is scaled by a master volume and can be muted. The two cores are chained: the mixed output of core 0 is the external input of core 1, and the output of core 1 is the final stereo output. The effect unit, voice synthesis and the data transfer feeding the data input sit outside the block. A one-cycle sample strobe, issued once per output sample (clock / 768), starts each pass.

Top module: `mixr_chain`

## Requirements
- R1: Voice v reaches bus b only when bit v of mask b is set and the voice-group bit of the mixer-enable word for bus b is set. Bus index b is 0 = dry L, 1 = dry R, 2 = wet L and 3 = wet R. The voice-group bits are 11 (dry L), 10 (dry R), 9 (wet L) and 8 (wet R). Left buses take the voice's left sample and right buses its right sample.
- R2: The data input of a side is scaled as sat((x*vol) >>> 15), with x and vol signed 16-bit values. It is added to bus b when mixer-enable bit 7-b is set.
- R3: The external input is scaled the same way by its own volume and is added to bus b when mixer-enable bit 3-b is set. Core 1's external input is core 0's mixed output. Core 0's external input is zero.
- R4: Every bus sum saturates to the signed 16-bit range [-32768, 32767]. Every scaled product saturates as well, so -32768 times -32768 gives 32767.
- R5: A core's output per side is sat((sat(dry + ((ret*rvol) >>> 15)) * mvol) >>> 15), where ret is the effect-return input.
- R6: When attribute bit 14 (mute) is set, the core's mixed output is 0.
- R7: When attribute bit 7 (effect enable) is clear, the core's wet sends are 0 and its effect return is treated as 0. When the bit is set, the wet sends carry wet L and wet R.
- R8: A strobe sampled at clock edge k raises out_valid for exactly the one cycle following edge k+3. Core 0's sends update at edge k, and core 1's sends and the final output update at edges k+2 and k+3 respectively. Outputs hold between passes.
- R9: After reset, all outputs are 0 and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | One-cycle start of a mix pass |
| voice_l | input | 2x24x16 | Left voice samples, [core][voice] |
| voice_r | input | 2x24x16 | Right voice samples, [core][voice] |
| mask | input | 2x4x24 | Per-voice bus masks, [core][bus] |
| mix_en | input | 2x12 | Mixer-enable word per core |
| attr | input | 2x16 | Attribute word per core (bit 14 mute, bit 7 effect enable) |
| data_l | input | 2x16 | PCM data input, left |
| data_r | input | 2x16 | PCM data input, right |
| dvol_l | input | 2x16 | Data input volume, left |
| dvol_r | input | 2x16 | Data input volume, right |
| xvol_l | input | 2x16 | External input volume, left (used by core 1) |
| xvol_r | input | 2x16 | External input volume, right (used by core 1) |
| ret_l | input | 2x16 | Effect return from the effect unit, left |
| ret_r | input | 2x16 | Effect return from the effect unit, right |
| rvol_l | input | 2x16 | Effect-return volume, left |
| rvol_r | input | 2x16 | Effect-return volume, right |
| mvol_l | input | 2x16 | Master volume, left |
| mvol_r | input | 2x16 | Master volume, right |
| send_l | output | 2x16 | Wet-left send to the effect unit |
| send_r | output | 2x16 | Wet-right send to the effect unit |
| out_l | output | 16 | Final left sample |
| out_r | output | 16 | Final right sample |
| out_valid | output | 1 | Final sample valid pulse |

## Verification
On every cycle, assertions check three things. A core's done pulse trails its start by two cycles, and the final valid trails the strobe by four. A muted core outputs zero. A core with effect enable clear sends nothing to the effect unit. The arithmetic can only be shown by the bench's scenarios, each compared with a model computed separately from the requirements. Those scenarios cover mask and mixer-enable routing, volume scaling, saturation at both ends of the range, and the carrying of core 0's result into core 1.

// File: rtl/mixr_pkg.sv
package mixr_pkg;
  localparam int SW = 16;
  localparam int NBUS = 4;

  // clamp a wide signed value to the signed sample range
  function automatic logic [SW-1:0] sat16(input logic signed [31:0] x);
    if (x > 32'sd32767) return 16'h7FFF;
    if (x < -32'sd32768) return 16'h8000;
    return x[SW-1:0];
  endfunction

  // signed sample times signed volume, Q15, saturated
  function automatic logic [SW-1:0] vol_mul(input logic [SW-1:0] s, input logic [SW-1:0] v);
    logic signed [31:0] p;
    p = 32'($signed(s)) * 32'($signed(v));
    return sat16(p >>> 15);
  endfunction
endpackage

// File: rtl/mixr_bus_sum.sv
module mixr_bus_sum #(
  parameter int NV = 24,
  parameter int W  = 16
) (
  input  logic [NV-1:0][W-1:0] voices,
  input  logic [NV-1:0]        sel,
  input  logic                 grp_en,
  output logic signed [31:0]   total
);
  always_comb begin
    total = '0;
    for (int v = 0; v < NV; v++) begin
      if (sel[v] && grp_en) total = total + 32'($signed(voices[v]));
    end
  end
endmodule

// File: rtl/mixr_core.sv
module mixr_core
  import mixr_pkg::*;
#(
  parameter int NV = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NV-1:0][SW-1:0] voice_l,
  input  logic [NV-1:0][SW-1:0] voice_r,
  input  logic [NBUS-1:0][NV-1:0] mask,
  input  logic [11:0]           mix_en,
  input  logic [15:0]           attr,
  input  logic [SW-1:0]         data_l, data_r, dvol_l, dvol_r,
  input  logic [SW-1:0]         ext_l, ext_r, xvol_l, xvol_r,
  input  logic [SW-1:0]         ret_l, ret_r, rvol_l, rvol_r,
  input  logic [SW-1:0]         mvol_l, mvol_r,
  output logic [SW-1:0]         send_l, send_r,
  output logic [SW-1:0]         mix_l, mix_r,
  output logic                  done
);
  localparam int MUTE_BIT = 14;
  localparam int FX_BIT   = 7;

  logic [SW-1:0] dsc_l, dsc_r, xsc_l, xsc_r;
  assign dsc_l = vol_mul(data_l, dvol_l);
  assign dsc_r = vol_mul(data_r, dvol_r);
  assign xsc_l = vol_mul(ext_l, xvol_l);
  assign xsc_r = vol_mul(ext_r, xvol_r);

  logic [NBUS-1:0][SW-1:0] bus_next;
  logic [NBUS-1:0][SW-1:0] bus_q;

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    localparam bit LEFT = (b % 2) == 0;
    logic signed [31:0] vsum, full;
    mixr_bus_sum #(.NV(NV), .W(SW)) u_sum (
      .voices (LEFT ? voice_l : voice_r),
      .sel    (mask[b]),
      .grp_en (mix_en[11-b]),
      .total  (vsum)
    );
    always_comb begin
      full = vsum;
      if (mix_en[7-b]) full = full + 32'($signed(LEFT ? dsc_l : dsc_r));
      if (mix_en[3-b]) full = full + 32'($signed(LEFT ? xsc_l : xsc_r));
      bus_next[b] = sat16(full);
    end
  end

  // stage 1: bus capture
  logic st1, fx_q, mute_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_q  <= '0;
      st1    <= 1'b0;
      fx_q   <= 1'b0;
      mute_q <= 1'b0;
    end else begin
      st1 <= start;
      if (start) begin
        bus_q  <= bus_next;
        fx_q   <= attr[FX_BIT];
        mute_q <= attr[MUTE_BIT];
      end
    end
  end

  assign send_l = fx_q ? bus_q[2] : '0;
  assign send_r = fx_q ? bus_q[3] : '0;

  // stage 2: effect return, master volume, mute
  logic [SW-1:0] ret_eff_l, ret_eff_r, fin_l, fin_r;
  assign ret_eff_l = fx_q ? vol_mul(ret_l, rvol_l) : '0;
  assign ret_eff_r = fx_q ? vol_mul(ret_r, rvol_r) : '0;
  assign fin_l = vol_mul(sat16(32'($signed(bus_q[0])) + 32'($signed(ret_eff_l))), mvol_l);
  assign fin_r = vol_mul(sat16(32'($signed(bus_q[1])) + 32'($signed(ret_eff_r))), mvol_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mix_l <= '0;
      mix_r <= '0;
      done  <= 1'b0;
    end else begin
      done <= st1;
      if (st1) begin
        mix_l <= mute_q ? '0 : fin_l;
        mix_r <= mute_q ? '0 : fin_r;
      end
    end
  end

  // R8: done trails start by two edges
  a_r8_done_lag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2));
  // R6: muted pass gives silence
  a_r6_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st1 && mute_q) |=> (mix_l == '0 && mix_r == '0));
  // R7: no send while effect is disabled
  a_r7_no_send: assert property (@(posedge clk) disable iff (!rst_n)
    !fx_q |-> (send_l == '0 && send_r == '0));
endmodule

// File: rtl/mixr_chain.sv
module mixr_chain
  import mixr_pkg::*;
#(
  parameter int NV = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         strobe,
  input  logic [1:0][NV-1:0][SW-1:0]   voice_l,
  input  logic [1:0][NV-1:0][SW-1:0]   voice_r,
  input  logic [1:0][NBUS-1:0][NV-1:0] mask,
  input  logic [1:0][11:0]             mix_en,
  input  logic [1:0][15:0]             attr,
  input  logic [1:0][SW-1:0]           data_l,
  input  logic [1:0][SW-1:0]           data_r,
  input  logic [1:0][SW-1:0]           dvol_l,
  input  logic [1:0][SW-1:0]           dvol_r,
  input  logic [1:0][SW-1:0]           xvol_l,
  input  logic [1:0][SW-1:0]           xvol_r,
  input  logic [1:0][SW-1:0]           ret_l,
  input  logic [1:0][SW-1:0]           ret_r,
  input  logic [1:0][SW-1:0]           rvol_l,
  input  logic [1:0][SW-1:0]           rvol_r,
  input  logic [1:0][SW-1:0]           mvol_l,
  input  logic [1:0][SW-1:0]           mvol_r,
  output logic [1:0][SW-1:0]           send_l,
  output logic [1:0][SW-1:0]           send_r,
  output logic [SW-1:0]                out_l,
  output logic [SW-1:0]                out_r,
  output logic                         out_valid
);
  localparam int NCORE = 2;

  logic [NCORE-1:0][SW-1:0] cmix_l, cmix_r, cext_l, cext_r;
  logic [NCORE-1:0]         cstart, cdone;

  // core 0 has no upstream; core c>0 is fed by core c-1
  assign cstart[0] = strobe;
  assign cext_l[0] = '0;
  assign cext_r[0] = '0;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    if (c > 0) begin : g_link
      assign cstart[c] = cdone[c-1];
      assign cext_l[c] = cmix_l[c-1];
      assign cext_r[c] = cmix_r[c-1];
    end
    mixr_core #(.NV(NV)) u_core (
      .clk(clk), .rst_n(rst_n), .start(cstart[c]),
      .voice_l(voice_l[c]), .voice_r(voice_r[c]), .mask(mask[c]),
      .mix_en(mix_en[c]), .attr(attr[c]),
      .data_l(data_l[c]), .data_r(data_r[c]), .dvol_l(dvol_l[c]), .dvol_r(dvol_r[c]),
      .ext_l(cext_l[c]), .ext_r(cext_r[c]), .xvol_l(xvol_l[c]), .xvol_r(xvol_r[c]),
      .ret_l(ret_l[c]), .ret_r(ret_r[c]), .rvol_l(rvol_l[c]), .rvol_r(rvol_r[c]),
      .mvol_l(mvol_l[c]), .mvol_r(mvol_r[c]),
      .send_l(send_l[c]), .send_r(send_r[c]),
      .mix_l(cmix_l[c]), .mix_r(cmix_r[c]), .done(cdone[c])
    );
  end

  assign out_l     = cmix_l[NCORE-1];
  assign out_r     = cmix_r[NCORE-1];
  assign out_valid = cdone[NCORE-1];

  // R8: final valid four edges after the strobe
  a_r8_chain_lag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(strobe, 4));
  // R9: quiet between reset and the first pass
  a_r9_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(strobe, 4));
endmodule

// File: tb/mixr_chain_test.sv
module mixr_chain_test;
  localparam int NV = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic [1:0][NV-1:0][15:0] voice_l, voice_r;
  logic [1:0][3:0][NV-1:0]  mask;
  logic [1:0][11:0] mix_en;
  logic [1:0][15:0] attr, data_l, data_r, dvol_l, dvol_r, xvol_l, xvol_r;
  logic [1:0][15:0] ret_l, ret_r, rvol_l, rvol_r, mvol_l, mvol_r;
  logic [1:0][15:0] send_l, send_r;
  logic [15:0] out_l, out_r;
  logic out_valid;

  always #4 clk = ~clk;

  mixr_chain #(.NV(NV)) uut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .voice_l(voice_l), .voice_r(voice_r),
    .mask(mask), .mix_en(mix_en), .attr(attr), .data_l(data_l), .data_r(data_r),
    .dvol_l(dvol_l), .dvol_r(dvol_r), .xvol_l(xvol_l), .xvol_r(xvol_r),
    .ret_l(ret_l), .ret_r(ret_r), .rvol_l(rvol_l), .rvol_r(rvol_r),
    .mvol_l(mvol_l), .mvol_r(mvol_r), .send_l(send_l), .send_r(send_r),
    .out_l(out_l), .out_r(out_r), .out_valid(out_valid)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [11:0] mix;
    logic [15:0] attr0, attr1;
    logic [23:0] mbase;
    logic [15:0] amp, dvol, xvol, rvol, mvol, data, ret;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{12'hFFF, 16'h0080, 16'h0080, 24'h000001, 16'd1000, 16'h4000, 16'h7FFF, 16'h4000, 16'h7FFF, 16'h2000, 16'h0400},
    '{12'hF00, 16'h0080, 16'h0080, 24'hA5A5A5, 16'hFC18, 16'h4000, 16'h7FFF, 16'h4000, 16'h6000, 16'h2000, 16'h0400},
    '{12'h0F0, 16'h0080, 16'h0080, 24'hFFFFFF, 16'h0100, 16'h8000, 16'h7FFF, 16'h4000, 16'h7FFF, 16'h8000, 16'h0000},
    '{12'hFFF, 16'h0080, 16'h0080, 24'hFFFFFF, 16'd30000, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h7FFF},
    '{12'hFFF, 16'h0080, 16'h4080, 24'h0F0F0F, 16'd2000, 16'h4000, 16'h4000, 16'h4000, 16'h7FFF, 16'h1000, 16'h1000},
    '{12'hFFF, 16'h0000, 16'h0000, 24'h333333, 16'd700, 16'h4000, 16'h6000, 16'h7FFF, 16'h7FFF, 16'h1000, 16'h7000},
    '{12'h8C8, 16'h0080, 16'h0080, 24'h0000FF, 16'd1500, 16'h3000, 16'h5000, 16'h2000, 16'h7000, 16'h0800, 16'hF000}
  };

  function automatic int clip(input int x);
    return (x > 32767) ? 32767 : ((x < -32768) ? -32768 : x);
  endfunction
  function automatic int sx(input logic [15:0] v);
    return int'($signed(v));
  endfunction
  function automatic int scale(input int s, input int v);
    int p;
    p = s * v;
    return clip(p >>> 15);
  endfunction
  function automatic logic [23:0] rotl(input logic [23:0] m, input int n);
    logic [47:0] d;
    d = {m, m} << (n % 24);
    return d[47:24];
  endfunction

  // model of one core: bus b order 0 dryL, 1 dryR, 2 wetL, 3 wetR
  task automatic model_core(input int c, input int ext_l, input int ext_r,
                            output int o_l, output int o_r, output int s_l, output int s_r);
    int bus [4];
    int ret_e, fin [2];
    bit fx, mute;
    for (int b = 0; b < 4; b++) begin
      int acc = 0;
      bit left = (b == 0 || b == 2);
      if (mix_en[c][11-b])
        for (int v = 0; v < NV; v++)
          if (mask[c][b][v]) acc += left ? sx(voice_l[c][v]) : sx(voice_r[c][v]);
      if (mix_en[c][7-b]) acc += left ? scale(sx(data_l[c]), sx(dvol_l[c]))
                                      : scale(sx(data_r[c]), sx(dvol_r[c]));
      if (mix_en[c][3-b]) acc += left ? scale(ext_l, sx(xvol_l[c])) : scale(ext_r, sx(xvol_r[c]));
      bus[b] = clip(acc);
    end
    fx = attr[c][7];
    mute = attr[c][14];
    s_l = fx ? bus[2] : 0;
    s_r = fx ? bus[3] : 0;
    for (int side = 0; side < 2; side++) begin
      ret_e = !fx ? 0 : (side == 0 ? scale(sx(ret_l[c]), sx(rvol_l[c])) : scale(sx(ret_r[c]), sx(rvol_r[c])));
      fin[side] = scale(clip(bus[side] + ret_e), side == 0 ? sx(mvol_l[c]) : sx(mvol_r[c]));
      if (mute) fin[side] = 0;
    end
    o_l = fin[0];
    o_r = fin[1];
  endtask

  task automatic apply(input vec_t t);
    for (int c = 0; c < 2; c++) begin
      for (int v = 0; v < NV; v++) begin
        voice_l[c][v] = t.amp + 16'(v * 97 * (c + 1));
        voice_r[c][v] = t.amp - 16'(v * 53);
      end
      for (int b = 0; b < 4; b++) mask[c][b] = rotl(t.mbase, b * 5 + c * 3);
      mix_en[c] = t.mix;
      attr[c] = (c == 0) ? t.attr0 : t.attr1;
      data_l[c] = t.data;  data_r[c] = t.data ^ 16'h0F00;
      dvol_l[c] = t.dvol;  dvol_r[c] = t.dvol;
      xvol_l[c] = t.xvol;  xvol_r[c] = t.xvol;
      ret_l[c] = t.ret;    ret_r[c] = t.ret + 16'd3;
      rvol_l[c] = t.rvol;  rvol_r[c] = t.rvol;
      mvol_l[c] = t.mvol;  mvol_r[c] = t.mvol;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int e0l, e0r, s0l, s0r, e1l, e1r, s1l, s1r;
    int hold_l, hold_r;
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 out_l", sx(out_l), 0);
    check("R9 out_valid", int'(out_valid), 0);
    check("R9 send_l core0", sx(send_l[0]), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 out_valid after reset", int'(out_valid), 0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i]);
      model_core(0, 0, 0, e0l, e0r, s0l, s0r);
      model_core(1, e0l, e0r, e1l, e1r, s1l, s1r);
      strobe = 1'b1;
      @(negedge clk);              // after edge k
      strobe = 1'b0;
      repeat (2) @(negedge clk);   // after edge k+2
      check("R8 no early valid", int'(out_valid), 0);
      @(negedge clk);              // after edge k+3
      check("R8 valid", int'(out_valid), 1);
      check("R1 R2 R3 R4 R5 out_l", sx(out_l), e1l);
      check("R1 R2 R3 R4 R5 out_r", sx(out_r), e1r);
      check("R7 send_l core0", sx(send_l[0]), s0l);
      check("R7 send_r core0", sx(send_r[0]), s0r);
      check("R7 send_l core1", sx(send_l[1]), s1l);
      check("R7 send_r core1", sx(send_r[1]), s1r);
      if (i == 4) check("R6 muted out_l", sx(out_l), 0);
      if (i == 5) check("R7 fx off send", sx(send_l[1]), 0);
      @(negedge clk);
      check("R8 pulse width", int'(out_valid), 0);
    end

    // R4: row 3 has 24 voices of about 30000 on the dry bus: sat to 32767, then master -32768
    apply(VECS[3]);
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 saturated negative master", sx(out_l), -32767);

    // R8: outputs hold when inputs change with no strobe
    hold_l = sx(out_l);
    hold_r = sx(out_r);
    apply(VECS[6]);
    repeat (5) @(negedge clk);
    check("R8 hold out_l", sx(out_l), hold_l);
    check("R8 hold out_r", sx(out_r), hold_r);
    check("R8 no spurious valid", int'(out_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule